// File: doc/BRIEF.md
# Decode-Stage Static Branch Direction Guesser

This block sits behind the instruction decoder and looks at one decode group of several slots per cycle. For every branch that the fetch-stage dynamic predictor left uncovered, it applies a fixed direction rule that depends on the branch class and, for conditional branches, on whether the target lies below or above the branch address. A taken guess cannot be acted on at fetch time because the branch has only just been decoded. It therefore becomes a late resteer: fetch is sent to the decoded target and the younger front-end work on the sequential path is discarded.

Each slot carries a valid bit, a two-bit class, its PC, its decoded target and a flag telling whether the dynamic predictor already gave a prediction. The block picks the oldest slot whose guess is taken. One cycle later it raises a redirect with that target, a flush for the younger front-end stages, and a mask of the later slots in the same group that must be squashed. A not-taken guess produces nothing, because sequential fetch is already the default. A back-end flush in the same cycle overrides everything.

Top module: `dec_static_predictor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `redirect_valid`, `fe_flush` and `squash_mask` are all zero.
- R2: A valid slot of class 1 (unconditional direct) with `slot_dyn_hit` low yields `redirect_valid` and `fe_flush` high, with `redirect_pc` equal to that slot's target.
- R3: A valid slot of class 2 (conditional direct) with `slot_dyn_hit` low and target less than or equal to its PC, compared unsigned, is guessed taken and redirects to its target. A target equal to the PC counts as backward.
- R4: A valid class 2 slot whose target is greater than its PC, compared unsigned, is guessed not taken and produces no redirect.
- R5: A valid slot of class 3 (indirect) or class 0 (no branch) never produces a redirect.
- R6: A slot with `slot_dyn_hit` high never produces a redirect, whatever its class and addresses.
- R7: Slot i has class in `slot_kind[2i+1:2i]`, PC in `slot_pc[PC_W*i +: PC_W]` and target in `slot_tgt[PC_W*i +: PC_W]`. Lower index means older. When several slots are guessed taken, the lowest-index slot supplies `redirect_pc`. `squash_mask` bit j is set exactly for the slots j above that winner, and the mask is zero whenever `redirect_valid` is low.
- R8: The outputs are registered. They reflect the decode group presented in the previous cycle and drop in the cycle after a group that produces no redirect.
- R9: `be_flush` high in the same cycle as a decode group cancels any redirect, flush and squash from that group.
- R10: When `dec_valid` is low, or a slot's `slot_valid` bit is low, that group or slot produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode group present this cycle |
| slot_valid | input | SLOTS | Per-slot instruction valid |
| slot_kind | input | 2*SLOTS | Per-slot branch class: 0 none, 1 unconditional direct, 2 conditional direct, 3 indirect |
| slot_pc | input | PC_W*SLOTS | Per-slot instruction address |
| slot_tgt | input | PC_W*SLOTS | Per-slot decoded target address |
| slot_dyn_hit | input | SLOTS | Dynamic predictor already covered this slot |
| be_flush | input | 1 | Back-end flush, overrides the static redirect |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | PC_W | Fetch redirect address |
| fe_flush | output | 1 | Flush younger front-end stages |
| squash_mask | output | SLOTS | Later slots of the redirecting group to squash |

## Verification
The bench targets a conditional target exactly equal to its PC. A design that used a strict compare would miss that redirect. It mixes forward and backward branches in one group with the taken one in a middle slot, which exposes an inverted priority or a squash mask that is off by one slot. Dynamic-hit slots and indirect branches carry backward targets, so a design that ignored the hit flag or treated indirect branches as conditional would redirect when it should not. Back-end flushes and dropped valid bits arrive alongside otherwise taken groups, to catch a redirect that leaks through either gate.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    BK_NONE   = 2'd0,
    BK_DIRECT = 2'd1,
    BK_COND   = 2'd2,
    BK_INDIR  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/sbp_slot_eval.sv
module sbp_slot_eval
  import sbp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            valid_i,
  input  logic [1:0]      kind_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] tgt_i,
  input  logic            dyn_hit_i,
  output logic            take_o
);
  br_kind_e kind;
  logic     backward;

  assign kind     = br_kind_e'(kind_i);
  // equal target counts as a backward (loop-closing) branch
  assign backward = (tgt_i <= pc_i);

  always_comb begin
    take_o = 1'b0;
    if (valid_i && !dyn_hit_i) begin
      unique case (kind)
        BK_DIRECT: take_o = 1'b1;
        BK_COND:   take_o = backward;
        BK_INDIR:  take_o = 1'b0;
        default:   take_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sbp_oldest_pick.sv
module sbp_oldest_pick #(
  parameter int SLOTS = 4,
  parameter int PC_W  = 32
) (
  input  logic [SLOTS-1:0]      take_i,
  input  logic [PC_W*SLOTS-1:0] tgt_i,
  output logic                  any_o,
  output logic [PC_W-1:0]       tgt_o,
  output logic [SLOTS-1:0]      mask_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    tgt_o  = '0;
    mask_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      // a slot is squashed once an older slot has already won
      mask_o[i] = found;
      if (!found && take_i[i]) begin
        found = 1'b1;
        tgt_o = tgt_i[i*PC_W +: PC_W];
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/sbp_redirect_reg.sv
module sbp_redirect_reg #(
  parameter int SLOTS = 4,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid_i,
  input  logic             be_flush_i,
  input  logic             any_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  logic [SLOTS-1:0] mask_i,
  output logic             redir_o,
  output logic [PC_W-1:0]  redir_pc_o,
  output logic             flush_o,
  output logic [SLOTS-1:0] mask_o
);
  logic             fire;
  logic             redir_d;
  logic [SLOTS-1:0] mask_d;
  logic             pc_en;

  always_comb begin
    fire    = dec_valid_i && any_i && !be_flush_i;
    redir_d = fire;
    mask_d  = fire ? mask_i : '0;
    pc_en   = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_o <= 1'b0;
      flush_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      redir_o <= redir_d;
      flush_o <= redir_d;
      mask_o  <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_pc_o <= '0;
    end else if (pc_en) begin
      redir_pc_o <= tgt_i;
    end
  end
endmodule

// File: rtl/dec_static_predictor.sv
module dec_static_predictor #(
  parameter int SLOTS = 4,
  parameter int PC_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  input  logic [SLOTS-1:0]      slot_valid,
  input  logic [2*SLOTS-1:0]    slot_kind,
  input  logic [PC_W*SLOTS-1:0] slot_pc,
  input  logic [PC_W*SLOTS-1:0] slot_tgt,
  input  logic [SLOTS-1:0]      slot_dyn_hit,
  input  logic                  be_flush,
  output logic                  redirect_valid,
  output logic [PC_W-1:0]       redirect_pc,
  output logic                  fe_flush,
  output logic [SLOTS-1:0]      squash_mask
);
  logic [SLOTS-1:0] take;
  logic             any_take;
  logic [PC_W-1:0]  win_tgt;
  logic [SLOTS-1:0] win_mask;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    sbp_slot_eval #(.PC_W(PC_W)) u_eval (
      .valid_i   (slot_valid[g]),
      .kind_i    (slot_kind[2*g +: 2]),
      .pc_i      (slot_pc[PC_W*g +: PC_W]),
      .tgt_i     (slot_tgt[PC_W*g +: PC_W]),
      .dyn_hit_i (slot_dyn_hit[g]),
      .take_o    (take[g])
    );
  end

  sbp_oldest_pick #(.SLOTS(SLOTS), .PC_W(PC_W)) u_pick (
    .take_i (take),
    .tgt_i  (slot_tgt),
    .any_o  (any_take),
    .tgt_o  (win_tgt),
    .mask_o (win_mask)
  );

  sbp_redirect_reg #(.SLOTS(SLOTS), .PC_W(PC_W)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid_i (dec_valid),
    .be_flush_i  (be_flush),
    .any_i       (any_take),
    .tgt_i       (win_tgt),
    .mask_i      (win_mask),
    .redir_o     (redirect_valid),
    .redir_pc_o  (redirect_pc),
    .flush_o     (fe_flush),
    .mask_o      (squash_mask)
  );
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int SLOTS = 4,
  parameter int PC_W  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dec_valid,
  input logic [SLOTS-1:0]      slot_valid,
  input logic [2*SLOTS-1:0]    slot_kind,
  input logic [PC_W*SLOTS-1:0] slot_pc,
  input logic [PC_W*SLOTS-1:0] slot_tgt,
  input logic [SLOTS-1:0]      slot_dyn_hit,
  input logic                  be_flush,
  input logic                  redirect_valid,
  input logic [PC_W-1:0]       redirect_pc,
  input logic                  fe_flush,
  input logic [SLOTS-1:0]      squash_mask
);
  logic s0_take;
  logic [SLOTS-1:0] above0;
  assign above0  = {{(SLOTS-1){1'b1}}, 1'b0};
  assign s0_take = dec_valid && !be_flush && slot_valid[0] && !slot_dyn_hit[0] &&
                   ((slot_kind[1:0] == 2'd1) ||
                    ((slot_kind[1:0] == 2'd2) && (slot_tgt[PC_W-1:0] <= slot_pc[PC_W-1:0])));

  assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    be_flush |=> !redirect_valid);

  assert_idle_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !redirect_valid);

  assert_dyn_stands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (&slot_dyn_hit)) |=> !redirect_valid);

  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |-> (squash_mask == '0));

  assert_slot0_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s0_take |=> (redirect_valid && (redirect_pc == $past(slot_tgt[PC_W-1:0])) &&
                 (squash_mask == above0)));

  assert_flush_with_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> fe_flush);
endmodule

bind dec_static_predictor sbp_checker #(.SLOTS(SLOTS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .slot_valid(slot_valid),
  .slot_kind(slot_kind), .slot_pc(slot_pc), .slot_tgt(slot_tgt),
  .slot_dyn_hit(slot_dyn_hit), .be_flush(be_flush),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .fe_flush(fe_flush), .squash_mask(squash_mask)
);

// File: tb/sim_dec_static_predictor.sv
module sim_dec_static_predictor;
  localparam int SLOTS = 4;
  localparam int PC_W  = 32;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, be_flush;
  logic [SLOTS-1:0] s_valid, s_dyn;
  logic [1:0]       s_kind [SLOTS];
  logic [PC_W-1:0]  s_pc   [SLOTS];
  logic [PC_W-1:0]  s_tgt  [SLOTS];
  logic [2*SLOTS-1:0]    kind_f;
  logic [PC_W*SLOTS-1:0] pc_f, tgt_f;
  logic                  redirect_valid, fe_flush;
  logic [PC_W-1:0]       redirect_pc;
  logic [SLOTS-1:0]      squash_mask;

  int checks = 0;
  int errors = 0;
  logic             e_valid;
  logic [PC_W-1:0]  e_pc;
  logic [SLOTS-1:0] e_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      kind_f[2*i +: 2]   = s_kind[i];
      pc_f[PC_W*i +: PC_W]  = s_pc[i];
      tgt_f[PC_W*i +: PC_W] = s_tgt[i];
    end
  end

  dec_static_predictor #(.SLOTS(SLOTS), .PC_W(PC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .slot_valid(s_valid),
    .slot_kind(kind_f), .slot_pc(pc_f), .slot_tgt(tgt_f), .slot_dyn_hit(s_dyn),
    .be_flush(be_flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .fe_flush(fe_flush), .squash_mask(squash_mask)
  );

  // reference rule from the requirements
  task automatic model();
    e_valid = 1'b0; e_pc = '0; e_mask = '0;
    if (dec_valid && !be_flush) begin
      for (int i = 0; i < SLOTS; i++) begin
        logic t;
        t = s_valid[i] && !s_dyn[i] &&
            (s_kind[i] == 2'd1 || (s_kind[i] == 2'd2 && s_tgt[i] <= s_pc[i]));
        if (e_valid) e_mask[i] = 1'b1;
        else if (t) begin e_valid = 1'b1; e_pc = s_tgt[i]; end
      end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (redirect_valid !== e_valid || fe_flush !== e_valid || squash_mask !== e_mask ||
        (e_valid && redirect_pc !== e_pc)) begin
      errors++;
      $display("FAIL %s: got v=%b f=%b pc=%h m=%b, expected v=%b f=%b pc=%h m=%b",
               tag, redirect_valid, fe_flush, redirect_pc, squash_mask,
               e_valid, e_valid, e_pc, e_mask);
    end
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic clear();
    dec_valid = 1'b0; be_flush = 1'b0; s_valid = '0; s_dyn = '0;
    for (int i = 0; i < SLOTS; i++) begin
      s_kind[i] = 2'd0; s_pc[i] = 32'h1000 + 32'(4*i); s_tgt[i] = '0;
    end
  endtask

  task automatic one(int slot, logic [1:0] k, logic [PC_W-1:0] tgt);
    clear();
    dec_valid = 1'b1; s_valid[slot] = 1'b1; s_kind[slot] = k; s_tgt[slot] = tgt;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1; e_valid = 0; e_mask = 0; e_pc = 0;
    compare("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after reset");

    one(0, 2'd1, 32'h2000);              step("R2 uncond slot0");
    one(1, 2'd2, 32'h0800);              step("R3 cond backward");
    one(2, 2'd2, 32'h1008);              step("R3 cond target equal pc");
    one(0, 2'd2, 32'h3000);              step("R4 cond forward");
    one(3, 2'd3, 32'h0100);              step("R5 indirect backward");
    one(0, 2'd0, 32'h0100);              step("R5 no branch");
    one(0, 2'd1, 32'h0100); s_dyn[0] = 1'b1; step("R6 dyn hit uncond");
    one(1, 2'd2, 32'h0100); s_dyn[1] = 1'b1; step("R6 dyn hit backward");

    clear(); dec_valid = 1'b1; s_valid = '1;
    s_kind[0] = 2'd2; s_tgt[0] = 32'h5000;
    s_kind[1] = 2'd3; s_tgt[1] = 32'h0004;
    s_kind[2] = 2'd2; s_tgt[2] = 32'h0040;
    s_kind[3] = 2'd1; s_tgt[3] = 32'h7000;
    step("R7 oldest taken in slot2");
    clear(); step("R8 deassert after idle");
    clear(); dec_valid = 1'b1; s_valid = '1;
    s_kind[0] = 2'd1; s_tgt[0] = 32'hA000;
    s_kind[1] = 2'd1; s_tgt[1] = 32'hB000;
    step("R7 slot0 wins over slot1");

    one(0, 2'd1, 32'h2000); be_flush = 1'b1; step("R9 back-end flush");
    one(0, 2'd1, 32'h2000); dec_valid = 1'b0; step("R10 group invalid");
    one(0, 2'd1, 32'h2000); s_valid = '0; s_kind[0] = 2'd1; step("R10 slot invalid");

    for (int n = 0; n < 3000; n++) begin
      dec_valid = ($urandom_range(0, 9) != 0);
      be_flush  = ($urandom_range(0, 15) == 0);
      s_valid   = SLOTS'($urandom);
      s_dyn     = SLOTS'($urandom) & SLOTS'($urandom);
      for (int i = 0; i < SLOTS; i++) begin
        int m;
        s_kind[i] = 2'($urandom_range(0, 3));
        s_pc[i]   = $urandom;
        m = $urandom_range(0, 2);
        if (m == 0)      s_tgt[i] = s_pc[i] - 32'($urandom_range(1, 4096));
        else if (m == 1) s_tgt[i] = s_pc[i] + 32'($urandom_range(1, 4096));
        else             s_tgt[i] = s_pc[i];
      end
      step("R8 random group");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule